// File: doc/BRIEF.md
# Atomic Register Update Bridge

This block sits between a 32-bit processor bus and a bank of 32-bit configuration registers. A single bus access can read or write a register directly, set or clear chosen bits, or update only part of a nibble, byte or halfword. The operation is not carried in the data or in a separate command field. It comes from the address window that the access hits. The bridge performs the whole read-modify-write inside the one cycle in which it accepts the access, so software never needs a read followed by a write, and no other access can land between the two halves of an update. An internal bank of registers stands in for the downstream registers.

The request side has a valid strobe with address, size, write flag and write data. The bridge never applies back-pressure: it accepts every access in the cycle that `bus_valid` is high, so it has no ready output. Every accepted access produces one response, one cycle later: `rsp_valid` together with read data and an error flag. The consumer of the response must take it in that cycle, because it is not held. Write data and read data are right-justified in the bus word: bit 0 of the bus is the lowest bit of the selected lane.

Top module: `atomreg_bridge`

## Requirements
- R1: While `rst_n` is low, and in the first response slot after reset, every register reads as zero and `rsp_valid`, `rsp_err` and `rsp_rdata` are 0.
- R2: The window is decoded from the address. 0x000–0x07F is direct, 0x080–0x0FF is set and 0x100–0x17F is clear, each with register = offset/4. 0x200–0x2FF is nibble-masked, 0x300–0x3FF is byte-masked and 0x400–0x4FF is halfword-masked, each with register = offset/8. Any other address is unmapped. Size codes are 0 = byte, 1 = halfword, 2 = word, and 3 is invalid.
- R3: A direct write replaces only the addressed lane with the right-justified write data. A byte write uses offset bits 1:0 as the byte lane. A halfword write needs offset bit 0 = 0 and uses bit 1 to pick bits 31:16. A word write needs offset bits 1:0 = 0.
- R4: A set write ORs the right-justified data into the addressed lane. Lanes and alignment follow the rules of R3. No other bit changes.
- R5: A clear write clears each bit of the addressed lane whose data bit is 1. Lanes and alignment follow the rules of R3. No other bit changes.
- R6: A nibble-masked write must be a byte access. Data bits 7:4 are the mask and bits 3:0 are the value. Offset bits 2:0 pick the nibble. Only the bits whose mask bit is 1 take the value.
- R7: A byte-masked write must be an aligned halfword access. Bits 15:8 are the mask and bits 7:0 are the value. Offset bits 2:1 pick the byte.
- R8: A halfword-masked write must be an aligned word access. Bits 31:16 are the mask and bits 15:0 are the value. Offset bit 2 picks bits 31:16.
- R9: A read is legal only in the direct window, and only as an aligned byte or halfword. It returns the addressed lane, right-justified and zero-extended. A write returns read data 0.
- R10: The following accesses change no register, return read data 0 and raise `rsp_err` for one cycle: a size that the window does not accept, a misaligned access, size code 3, an unmapped address, a word read, and a read outside the direct window.
- R11: `rsp_valid` is high exactly one cycle after each cycle with `bus_valid` high. A write takes effect at the edge that accepts it, so an access in the very next cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access present this cycle; always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| bus_addr | input | 11 | Byte address: window and offset |
| bus_wdata | input | 32 | Right-justified write data, or mask and value |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access was rejected and ignored |

## Verification
Every response is due exactly one clock after the access that caused it. A register update is due at that same edge, so it can be seen through a read issued in the next cycle. The bench drives each access half a period before the rising edge and compares `rsp_valid`, `rsp_err` and `rsp_rdata` with its behavioural model half a period after that edge. It then issues the next access at once, which also covers back-to-back read-after-write. Register contents are checked at the ports by reading every register back as two direct halfword reads after the directed, error and random phases.

// File: rtl/atomreg_pkg.sv
package atomreg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 11;
  localparam int IDX_W  = 5;
  localparam int SH_W   = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_DIRECT = 3'd0,
    OP_SET    = 3'd1,
    OP_CLEAR  = 3'd2,
    OP_MASK4  = 3'd3,
    OP_MASK8  = 3'd4,
    OP_MASK16 = 3'd5,
    OP_NONE   = 3'd6
  } op_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef struct packed {
    op_e              op;
    logic [IDX_W-1:0] idx;
    logic [SH_W-1:0]  shamt;
    logic             err;
    logic             rd;
    logic             wr;
  } dec_t;
endpackage

// File: rtl/atomreg_decode.sv
module atomreg_decode
  import atomreg_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic              valid,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic bad;
  logic plain;

  always_comb begin
    dec = '0;
    bad = 1'b0;
    case (addr[10:8])
      3'd0:    dec.op = addr[7] ? OP_SET : OP_DIRECT;
      3'd1:    dec.op = addr[7] ? OP_NONE : OP_CLEAR;
      3'd2:    dec.op = OP_MASK4;
      3'd3:    dec.op = OP_MASK8;
      3'd4:    dec.op = OP_MASK16;
      default: dec.op = OP_NONE;
    endcase
    plain   = (dec.op == OP_DIRECT) || (dec.op == OP_SET) || (dec.op == OP_CLEAR);
    dec.idx = plain ? addr[6:2] : addr[7:3];

    case (dec.op)
      OP_DIRECT, OP_SET, OP_CLEAR: begin
        case (size)
          SZ_BYTE: dec.shamt = {addr[1:0], 3'b000};
          SZ_HALF: begin
            dec.shamt = {addr[1], 4'b0000};
            bad = addr[0];
          end
          SZ_WORD: bad = (addr[1:0] != 2'b00);
          default: bad = 1'b1;
        endcase
      end
      OP_MASK4: begin
        dec.shamt = {addr[2:0], 2'b00};
        bad = (size != SZ_BYTE);
      end
      OP_MASK8: begin
        dec.shamt = {addr[2:1], 3'b000};
        bad = (size != SZ_HALF) || addr[0];
      end
      OP_MASK16: begin
        dec.shamt = {addr[2], 4'b0000};
        bad = (size != SZ_WORD) || (addr[1:0] != 2'b00);
      end
      default: bad = 1'b1;
    endcase

    if (!write && ((dec.op != OP_DIRECT) || (size == SZ_WORD)))
      bad = 1'b1;
    if (int'(dec.idx) >= NUM_REGS)
      bad = 1'b1;

    dec.err = valid && bad;
    dec.wr  = valid && write && !bad;
    dec.rd  = valid && !write && !bad;
  end
endmodule

// File: rtl/atomreg_merge.sv
module atomreg_merge
  import atomreg_pkg::*;
(
  input  op_e               op,
  input  logic [1:0]        size,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] fmask,
  output logic [DATA_W-1:0] new_val
);
  logic [DATA_W-1:0] lane;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] fval;

  always_comb begin
    case (size)
      SZ_BYTE: lane = 32'h0000_00FF;
      SZ_HALF: lane = 32'h0000_FFFF;
      default: lane = 32'hFFFF_FFFF;
    endcase
    raw = wdata & lane;
    case (op)
      OP_DIRECT: begin
        fmask = lane << shamt;
        fval  = raw << shamt;
      end
      OP_SET: begin
        fmask = raw << shamt;
        fval  = '1;
      end
      OP_CLEAR: begin
        fmask = raw << shamt;
        fval  = '0;
      end
      OP_MASK4: begin
        fmask = {28'd0, wdata[7:4]} << shamt;
        fval  = {28'd0, wdata[3:0]} << shamt;
      end
      OP_MASK8: begin
        fmask = {24'd0, wdata[15:8]} << shamt;
        fval  = {24'd0, wdata[7:0]} << shamt;
      end
      OP_MASK16: begin
        fmask = {16'd0, wdata[31:16]} << shamt;
        fval  = {16'd0, wdata[15:0]} << shamt;
      end
      default: begin
        fmask = '0;
        fval  = '0;
      end
    endcase
    new_val = (old_val & ~fmask) | (fval & fmask);
  end
endmodule

// File: rtl/atomreg_bank.sv
module atomreg_bank
  import atomreg_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [DATA_W-1:0]                wval,
  output logic [DATA_W-1:0]                rval,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  bank_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (we && (int'(idx) == g))
        q <= wval;
    end
    assign bank_q[g] = q;
  end

  assign rval = (int'(idx) < NUM_REGS) ? bank_q[idx] : '0;

  // R11: a write is visible in the addressed register after its edge
  a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> bank_q[$past(idx)] == $past(wval));

  // R10: without a write enable nothing in the bank moves
  a_r10_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bank_q));
endmodule

// File: rtl/atomreg_bridge.sv
module atomreg_bridge
  import atomreg_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [10:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  dec_t                             dec;
  logic [DATA_W-1:0]                old_val;
  logic [DATA_W-1:0]                new_val;
  logic [DATA_W-1:0]                fmask;
  logic [DATA_W-1:0]                rfield;
  logic [NUM_REGS-1:0][DATA_W-1:0]  bank_q;

  atomreg_decode #(.NUM_REGS(NUM_REGS)) i_decode (
    .valid (bus_valid),
    .write (bus_write),
    .size  (bus_size),
    .addr  (bus_addr),
    .dec   (dec)
  );

  atomreg_merge i_merge (
    .op      (dec.op),
    .size    (bus_size),
    .shamt   (dec.shamt),
    .wdata   (bus_wdata),
    .old_val (old_val),
    .fmask   (fmask),
    .new_val (new_val)
  );

  atomreg_bank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (dec.wr),
    .idx    (dec.idx),
    .wval   (new_val),
    .rval   (old_val),
    .bank_q (bank_q)
  );

  assign rfield = (old_val >> dec.shamt) &
                  ((bus_size == SZ_BYTE) ? 32'h0000_00FF : 32'h0000_FFFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_valid;
      rsp_err   <= dec.err;
      rsp_rdata <= dec.rd ? rfield : '0;
    end
  end

  // R11: one response per accepted access, one cycle later
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid);
  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !rsp_valid);

  // R10: an error response carries no data and belongs to an access
  a_r10_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));

  // R6: a non-byte access to the nibble window is rejected
  a_r6_size_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[10:8] == 3'd2 && bus_size != SZ_BYTE) |=> rsp_err);

  // R9: a write never returns data
  a_r9_write_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |=> rsp_rdata == '0);

  // R4: set can only raise bits
  a_r4_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.wr && dec.op == OP_SET) |-> (old_val & ~new_val) == '0);

  // R5: clear can only lower bits
  a_r5_clear_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.wr && dec.op == OP_CLEAR) |-> (new_val & ~old_val) == '0);

  // R7: bits outside the selected field are untouched
  a_r7_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
    dec.wr |-> ((new_val ^ old_val) & ~fmask) == '0);
endmodule

// File: tb/test_atomreg_bridge.sv
module test_atomreg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;
  bit [31:0] model [32];

  atomreg_bridge i_atomreg_bridge (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural model of one access
  function automatic void model_op(input bit w, input int sz, input int a, input bit [31:0] wd,
                                   output bit e, output bit [31:0] rd);
    int kind, base, r, off, nbytes;
    bit [63:0] lm, m, v, sh_wd;
    e = 0; rd = 0; kind = -1; base = 0;
    if (a < 'h80) begin kind = 0; base = 'h0; end
    else if (a < 'h100) begin kind = 1; base = 'h80; end
    else if (a < 'h180) begin kind = 2; base = 'h100; end
    else if (a < 'h200) kind = -1;
    else if (a < 'h300) begin kind = 3; base = 'h200; end
    else if (a < 'h400) begin kind = 4; base = 'h300; end
    else if (a < 'h500) begin kind = 5; base = 'h400; end
    if (kind < 0) begin e = 1; return; end
    nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
    if (nbytes == 0) begin e = 1; return; end
    if (kind <= 2) begin r = (a - base) / 4; off = (a - base) % 4; end
    else begin r = (a - base) / 8; off = (a - base) % 8; end
    if (!w) begin
      if (kind != 0 || nbytes == 4 || (off % nbytes) != 0) begin e = 1; return; end
      rd = 32'((64'(model[r]) >> (8*off)) & ((64'd1 << (8*nbytes)) - 1));
      return;
    end
    if (kind <= 2) begin
      if ((off % nbytes) != 0) begin e = 1; return; end
      lm = ((64'd1 << (8*nbytes)) - 1) << (8*off);
      sh_wd = (64'(wd) << (8*off)) & lm;
      case (kind)
        0: model[r] = 32'((64'(model[r]) & ~lm) | sh_wd);
        1: model[r] = model[r] | 32'(sh_wd);
        default: model[r] = model[r] & ~32'(sh_wd);
      endcase
      return;
    end
    if (kind == 3) begin
      if (nbytes != 1) begin e = 1; return; end
      m = 64'((wd >> 4) & 32'hF) << (4*off);
      v = 64'(wd & 32'hF) << (4*off);
    end else if (kind == 4) begin
      if (nbytes != 2 || (off % 2) != 0) begin e = 1; return; end
      m = 64'((wd >> 8) & 32'hFF) << (8*(off/2));
      v = 64'(wd & 32'hFF) << (8*(off/2));
    end else begin
      if (nbytes != 4 || (off % 4) != 0) begin e = 1; return; end
      m = 64'((wd >> 16) & 32'hFFFF) << (16*(off/4));
      v = 64'(wd & 32'hFFFF) << (16*(off/4));
    end
    model[r] = (model[r] & ~32'(m)) | (32'(v) & 32'(m));
  endfunction

  task automatic access(input bit w, input int sz, input int a, input bit [31:0] wd, input string tag);
    bit e;
    bit [31:0] rd;
    model_op(w, sz, a, wd, e, rd);
    bus_valid = 1'b1; bus_write = w; bus_size = 2'(sz);
    bus_addr = 11'(a); bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    check(tag, "rsp_valid", longint'(rsp_valid), 1);
    check(tag, "rsp_err", longint'(rsp_err), longint'(e));
    check(tag, "rsp_rdata", longint'(rsp_rdata), longint'(rd));
  endtask

  task automatic idle(input string tag);
    bus_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(tag, "idle rsp_valid", longint'(rsp_valid), 0);
    check(tag, "idle rsp_err", longint'(rsp_err), 0);
  endtask

  task automatic dump(input string tag);
    for (int r = 0; r < 32; r++) begin
      access(0, 1, 4*r, 0, tag);
      access(0, 1, 4*r + 2, 0, tag);
    end
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", longint'(rsp_valid), 0);
    check("R1", "rsp_rdata in reset", longint'(rsp_rdata), 0);
    rst_n = 1'b1;
    idle("R1");
    dump("R1");

    // R3 direct writes and R9 reads
    access(1, 2, 'h0C, 32'h1234_5678, "R3");
    access(0, 1, 'h0C, 0, "R9");
    access(0, 1, 'h0E, 0, "R9");
    access(0, 0, 'h0F, 0, "R9");
    access(0, 0, 'h0D, 0, "R9");
    access(1, 1, 'h12, 32'hFFFF_ABCD, "R3");
    access(1, 1, 'h10, 32'h0000_EF01, "R3");
    for (int b = 0; b < 4; b++) access(1, 0, 'h14 + b, 32'h33 + 32'h11*b, "R3");
    access(0, 1, 'h16, 0, "R3");

    // R4 set, R5 clear
    access(1, 2, 'h80 + 'h18, 32'hAAAA_AAAA, "R4");
    access(1, 0, 'h80 + 'h18 + 1, 32'h55, "R4");
    access(0, 1, 'h18, 0, "R4");
    access(1, 2, 'h100 + 'h18, 32'h00FF_0000, "R5");
    access(1, 0, 'h100 + 'h18 + 3, 32'h0F, "R5");
    access(0, 1, 'h1A, 0, "R5");

    // R8 halfword-masked
    access(1, 2, 'h400 + 8*7, 32'hFFFF_5555, "R8");
    access(1, 2, 'h400 + 8*7 + 4, 32'h01FF_01AA, "R8");
    access(0, 1, 'h1E, 0, "R8");
    // R7 byte-masked
    access(1, 2, 'h20, 32'hFFFF_FFFF, "R7");
    for (int b = 0; b < 4; b++) access(1, 1, 'h300 + 8*8 + 2*b, 32'h0F00 | (32'h11*b), "R7");
    access(0, 1, 'h22, 0, "R7");
    // R6 nibble-masked
    for (int n = 0; n < 8; n++) access(1, 0, 'h200 + 8*10 + n, 32'h60 | n, "R6");
    access(0, 1, 'h28, 0, "R6");
    access(0, 1, 'h2A, 0, "R6");

    // R10 rejected accesses
    access(1, 1, 'h200 + 8*10, 32'h00FF, "R10");
    access(1, 2, 'h300 + 8*8, 32'hFFFF_FFFF, "R10");
    access(1, 1, 'h300 + 8*8 + 1, 32'hFF00, "R10");
    access(1, 0, 'h400 + 8*7, 32'hFF, "R10");
    access(1, 1, 'h0D, 32'hFFFF, "R10");
    access(1, 2, 'h0E, 32'hFFFF_FFFF, "R10");
    access(1, 3, 'h0C, 32'hFFFF_FFFF, "R10");
    access(1, 2, 'h180, 32'hFFFF_FFFF, "R10");
    access(1, 2, 'h500, 32'hFFFF_FFFF, "R10");
    access(0, 2, 'h0C, 0, "R10");
    access(0, 1, 'h80 + 'h0C, 0, "R10");
    access(0, 0, 'h200, 0, "R10");
    dump("R10");

    // R11 back-to-back write then read
    access(1, 2, 'h7C, 32'hCAFE_F00D, "R11");
    access(0, 1, 'h7E, 0, "R11");
    access(1, 0, 'h100 + 'h7C, 32'h0D, "R11");
    access(0, 0, 'h7C, 0, "R11");
    idle("R11");

    // R2 mixed traffic across all windows
    for (int i = 0; i < 600; i++)
      access(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 'h53F),
             $urandom(), "R2");
    dump("R2");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule